// File: doc/BRIEF.md
# Exception Entry Sequencer

This block turns an exception request from a fault source into the complete processor-state update needed to enter a handler. A request carries a class code, a set of fault flags, a program-exception subtype, the current machine-state word, the next instruction address and the faulting data address. One cycle later the block commits all of the following together, in a single entry pulse: the saved return address, the saved state word, the data-fault cause word, the fault address, the new machine-state word and the handler fetch address.

External and timer interrupts that arrive while interrupts are disabled are kept in two pending flags. A pending interrupt is taken on a later cycle with no new request once the interrupt-enable bit reads 1. A machine-check raised while machine-checks are disabled gives a fatal pulse instead of an entry. A floating-point program exception raised while both FP exception-mode bits are 0 is discarded.

Machine-state bit positions used throughout: LE 0, RI 1, DR 4, IR 5, IP 6, FE1 8, BE 9, SE 10, FE0 11, ME 12, FP 13, PR 14, EE 15, ILE 16, POW 18.

Top module: `exc_entry`

## Requirements
- R1: `req_kind` codes 0..10 select reset, machine-check, data-storage, instruction-storage, external, alignment, program, FPU-unavailable, timer, system-call and trace. Their exception numbers are 0x1, 0x2, 0x3, 0x4, 0x5, 0x6, 0x7, 0x8, 0x9, 0xC and 0xD, and `pc_o` is that number shifted left by 8. Codes 11..15 are ignored.
- R2: On a data-storage entry, `dsisr_o` is rebuilt from zero using the `err_flags` bits: bit 0 (miss) gives bit 30; otherwise bit 1 (protection) gives bit 27; otherwise bit 2 (unsupported) gives bit 31, plus bit 26 if bit 3 (direct-store) is also set. Flag bit 4 (store) adds bit 25 and flag bit 5 (external-control) adds bit 20. `dar_o` takes `fault_addr`, and `srr1_o` is `msr_in` with its upper 16 bits cleared.
- R3: On an instruction-storage entry, `srr1_o` is `msr_in[15:0]` with an upper half that is cleared and then given one bit: bit 30 for flag 0 (miss), which has priority; otherwise bit 28 for flag 6 (no-execute), flag 7 (guarded) or flag 3 (direct-store); otherwise bit 27.
- R4: On a program entry, `srr1_o` has its upper half cleared with bit 16 set, plus one bit chosen by `prog_kind`: 0 illegal gives bit 19, 1 privileged gives bit 18, 2 trap gives bit 17, 3 floating-point gives bit 20.
- R5: Data-storage, instruction-storage, external, timer, system-call, trace and reset save `nip_in` in `srr0_o`. Program, alignment and FPU-unavailable save `nip_in - 4`. Classes other than storage and program save `msr_in` unchanged in `srr1_o`.
- R6: External and timer requests made while EE is 0 produce no entry and set `pend_o[0]` or `pend_o[1]` respectively. On a cycle with no request and EE at 1, a pending external is taken before a pending timer, using the current `nip_in` and `msr_in`, and its flag is cleared. A new request in the same cycle takes precedence over any pending one.
- R7: `msr_o` is `msr_in` with POW, EE, PR, FP, FE0, FE1, SE, BE, IR, DR and RI cleared and LE loaded from ILE. All other bits are kept.
- R8: A machine-check with ME at 0 pulses `fatal_o` for one cycle and changes no other output. With ME at 1 it enters with ME cleared in `msr_o` and leaves `srr0_o` unchanged.
- R9: A reset entry with IP at 1 adds 0xFFC00 to the exception number, so `pc_o` becomes 0x0FFC0100. With IP at 0, `pc_o` is 0x100.
- R10: A floating-point program request with both FE0 and FE1 at 0 produces no entry and changes no output.
- R11: `entry_o` pulses for one cycle, in the cycle after the accepted request. All saved registers and `pc_o` hold their values in every other cycle. `dar_o` is written only by data-storage and alignment entries, and `dsisr_o` only by data-storage entries.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Exception request this cycle |
| req_kind | input | 4 | Exception class code |
| err_flags | input | 8 | Fault detail flags |
| prog_kind | input | 2 | Program-exception subtype |
| msr_in | input | 32 | Current machine-state word |
| nip_in | input | 32 | Next instruction address |
| fault_addr | input | 32 | Faulting data address |
| entry_o | output | 1 | Entry committed (one cycle) |
| fatal_o | output | 1 | Machine-check while disabled |
| pend_o | output | 2 | Pending timer (bit 1) and external (bit 0) |
| srr0_o | output | 32 | Saved return address |
| srr1_o | output | 32 | Saved state word |
| dsisr_o | output | 32 | Data-fault cause word |
| dar_o | output | 32 | Fault address |
| msr_o | output | 32 | New machine-state word |
| pc_o | output | 32 | Handler fetch address |

## Verification
Two functions of this block can fall in the same cycle. One is a fresh request; the other is the release of a deferred external or timer interrupt when EE turns to 1. The bench first parks both an external and a timer interrupt. It then raises EE in the same cycle as a system-call request. Three entries must follow in order: the system call at 0xC00, then the external at 0x500, then the timer at 0x900. The pending flags must clear one at a time as each interrupt is taken.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter logic [19:0] RST_PREFIX = 20'hFFC00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [3:0]  req_kind,
  input  logic [7:0]  err_flags,
  input  logic [1:0]  prog_kind,
  input  logic [31:0] msr_in,
  input  logic [31:0] nip_in,
  input  logic [31:0] fault_addr,
  output logic        entry_o,
  output logic        fatal_o,
  output logic [1:0]  pend_o,
  output logic [31:0] srr0_o,
  output logic [31:0] srr1_o,
  output logic [31:0] dsisr_o,
  output logic [31:0] dar_o,
  output logic [31:0] msr_o,
  output logic [31:0] pc_o
);
  localparam int B_LE = 0, B_RI = 1, B_DR = 4, B_IR = 5, B_IP = 6, B_FE1 = 8,
                 B_BE = 9, B_SE = 10, B_FE0 = 11, B_ME = 12, B_FP = 13,
                 B_PR = 14, B_EE = 15, B_ILE = 16, B_POW = 18;
  localparam logic [31:0] CLR_MASK = (32'd1 << B_POW) | (32'd1 << B_EE) |
    (32'd1 << B_PR) | (32'd1 << B_FP) | (32'd1 << B_FE0) | (32'd1 << B_FE1) |
    (32'd1 << B_SE) | (32'd1 << B_BE) | (32'd1 << B_IR) | (32'd1 << B_DR) |
    (32'd1 << B_RI) | (32'd1 << B_LE);

  localparam logic [3:0] K_RST = 4'd0, K_MCK = 4'd1, K_DST = 4'd2, K_IST = 4'd3,
                         K_EXT = 4'd4, K_ALN = 4'd5, K_PRG = 4'd6, K_FPU = 4'd7,
                         K_TMR = 4'd8, K_SYS = 4'd9, K_TRC = 4'd10;

  logic [1:0]  pend_q;
  logic        ee;
  logic        act;
  logic [3:0]  kind;
  logic        go, fatal, defer_ext, defer_tmr, take_ext, take_tmr;
  logic        wr_srr0, wr_dsisr, wr_dar, use_cur;
  logic [19:0] num;
  logic [31:0] srr1_n, dsisr_n, msr_n;

  assign ee = msr_in[B_EE];

  always_comb begin
    act = 1'b0;
    kind = req_kind;
    take_ext = 1'b0;
    take_tmr = 1'b0;
    if (req_valid) begin
      act = 1'b1;
    end else if (ee && pend_q[0]) begin
      act = 1'b1;
      kind = K_EXT;
      take_ext = 1'b1;
    end else if (ee && pend_q[1]) begin
      act = 1'b1;
      kind = K_TMR;
      take_tmr = 1'b1;
    end
  end

  always_comb begin
    go = 1'b0;
    fatal = 1'b0;
    defer_ext = 1'b0;
    defer_tmr = 1'b0;
    wr_srr0 = 1'b1;
    wr_dsisr = 1'b0;
    wr_dar = 1'b0;
    use_cur = 1'b0;
    num = 20'd0;
    srr1_n = msr_in;
    dsisr_n = 32'd0;
    if (act) begin
      case (kind)
        K_RST: begin
          go = 1'b1;
          num = 20'h1 + (msr_in[B_IP] ? RST_PREFIX : 20'd0);
        end
        K_MCK: begin
          num = 20'h2;
          wr_srr0 = 1'b0;
          if (msr_in[B_ME]) go = 1'b1;
          else fatal = 1'b1;
        end
        K_DST: begin
          go = 1'b1;
          num = 20'h3;
          wr_dsisr = 1'b1;
          wr_dar = 1'b1;
          srr1_n = {16'd0, msr_in[15:0]};
          if (err_flags[0]) dsisr_n[30] = 1'b1;
          else if (err_flags[1]) dsisr_n[27] = 1'b1;
          else if (err_flags[2]) begin
            dsisr_n[31] = 1'b1;
            dsisr_n[26] = err_flags[3];
          end
          dsisr_n[25] = err_flags[4];
          dsisr_n[20] = err_flags[5];
        end
        K_IST: begin
          go = 1'b1;
          num = 20'h4;
          srr1_n = {16'd0, msr_in[15:0]};
          if (err_flags[0]) srr1_n[30] = 1'b1;
          else if (err_flags[6] | err_flags[7] | err_flags[3]) srr1_n[28] = 1'b1;
          else srr1_n[27] = 1'b1;
        end
        K_EXT: begin
          num = 20'h5;
          if (ee) go = 1'b1;
          else defer_ext = 1'b1;
        end
        K_ALN: begin
          go = 1'b1;
          num = 20'h6;
          use_cur = 1'b1;
          wr_dar = 1'b1;
        end
        K_PRG: begin
          num = 20'h7;
          use_cur = 1'b1;
          srr1_n = {15'd0, 1'b1, msr_in[15:0]};
          go = 1'b1;
          case (prog_kind)
            2'd0: srr1_n[19] = 1'b1;
            2'd1: srr1_n[18] = 1'b1;
            2'd2: srr1_n[17] = 1'b1;
            default: begin
              srr1_n[20] = 1'b1;
              if (!msr_in[B_FE0] && !msr_in[B_FE1]) go = 1'b0;
            end
          endcase
        end
        K_FPU: begin
          go = 1'b1;
          num = 20'h8;
          use_cur = 1'b1;
        end
        K_TMR: begin
          num = 20'h9;
          if (ee) go = 1'b1;
          else defer_tmr = 1'b1;
        end
        K_SYS: begin
          go = 1'b1;
          num = 20'hC;
        end
        K_TRC: begin
          go = 1'b1;
          num = 20'hD;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    msr_n = msr_in & ~CLR_MASK;
    msr_n[B_LE] = msr_in[B_ILE];
    if (kind == K_MCK) msr_n[B_ME] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 2'b00;
      entry_o <= 1'b0;
      fatal_o <= 1'b0;
      srr0_o  <= 32'd0;
      srr1_o  <= 32'd0;
      dsisr_o <= 32'd0;
      dar_o   <= 32'd0;
      msr_o   <= 32'd0;
      pc_o    <= 32'd0;
    end else begin
      entry_o <= go;
      fatal_o <= fatal;
      if (defer_ext) pend_q[0] <= 1'b1;
      else if (take_ext || (go && kind == K_EXT)) pend_q[0] <= 1'b0;
      if (defer_tmr) pend_q[1] <= 1'b1;
      else if (take_tmr || (go && kind == K_TMR)) pend_q[1] <= 1'b0;
      if (go) begin
        if (wr_srr0) srr0_o <= use_cur ? nip_in - 32'd4 : nip_in;
        srr1_o <= srr1_n;
        msr_o  <= msr_n;
        pc_o   <= {4'd0, num, 8'd0};
        if (wr_dsisr) dsisr_o <= dsisr_n;
        if (wr_dar) dar_o <= fault_addr;
      end
    end
  end

  assign pend_o = pend_q;
endmodule

module exc_entry_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [3:0]  req_kind,
  input logic [31:0] msr_in,
  input logic        entry_o,
  input logic        fatal_o,
  input logic [1:0]  pend_o,
  input logic [31:0] srr0_o,
  input logic [31:0] msr_o,
  input logic [31:0] pc_o
);
  // R1
  vec_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> pc_o[7:0] == 8'd0);
  // R7
  new_msr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    entry_o |-> (!msr_o[15] && !msr_o[14] && !msr_o[4] && !msr_o[5] && msr_o[0] == msr_o[16]));
  // R8
  fatal_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |-> !entry_o);
  // R8
  mck_me_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (entry_o && pc_o == 32'h200) |-> !msr_o[12]);
  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !entry_o |-> ($stable(srr0_o) && $stable(pc_o) && $stable(msr_o)));
  // R6
  defer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 4'd4 && !msr_in[15]) |=> (pend_o[0] && !entry_o));
endmodule

bind exc_entry exc_entry_chk u_exc_entry_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .msr_in(msr_in), .entry_o(entry_o), .fatal_o(fatal_o), .pend_o(pend_o),
  .srr0_o(srr0_o), .msr_o(msr_o), .pc_o(pc_o)
);

// File: tb/test_exc_entry.sv
`timescale 1ns/1ps
module test_exc_entry;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  req_kind = 4'd0;
  logic [7:0]  err_flags = 8'd0;
  logic [1:0]  prog_kind = 2'd0;
  logic [31:0] msr_in = 32'd0;
  logic [31:0] nip_in = 32'd0;
  logic [31:0] fault_addr = 32'd0;
  logic        entry_o, fatal_o;
  logic [1:0]  pend_o;
  logic [31:0] srr0_o, srr1_o, dsisr_o, dar_o, msr_o, pc_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  exc_entry i_exc_entry (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .err_flags(err_flags), .prog_kind(prog_kind), .msr_in(msr_in),
    .nip_in(nip_in), .fault_addr(fault_addr), .entry_o(entry_o),
    .fatal_o(fatal_o), .pend_o(pend_o), .srr0_o(srr0_o), .srr1_o(srr1_o),
    .dsisr_o(dsisr_o), .dar_o(dar_o), .msr_o(msr_o), .pc_o(pc_o)
  );

  function automatic logic [31:0] exp_msr(input logic [31:0] m, input bit mck);
    logic [31:0] r;
    r = m;
    r[18] = 0; r[15] = 0; r[14] = 0; r[13] = 0; r[11] = 0; r[8] = 0;
    r[10] = 0; r[9] = 0; r[5] = 0; r[4] = 0; r[1] = 0;
    r[0] = m[16];
    if (mck) r[12] = 0;
    return r;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic fire(input logic [3:0] k, input logic [7:0] f, input logic [1:0] pk,
                      input logic [31:0] m, input logic [31:0] nip, input logic [31:0] fa);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; err_flags = f; prog_kind = pk;
    msr_in = m; nip_in = nip; fault_addr = fa;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; msr_in = 32'd0;
  endtask

  task automatic t_reset_state();
    chk("R12", "entry", {31'd0, entry_o}, 0);
    chk("R12", "pc", pc_o, 0);
    chk("R12", "srr0", srr0_o, 0);
    chk("R12", "srr1", srr1_o, 0);
    chk("R12", "dsisr", dsisr_o, 0);
    chk("R12", "dar", dar_o, 0);
    chk("R12", "msr", msr_o, 0);
    chk("R12", "pend", {30'd0, pend_o}, 0);
  endtask

  task automatic t_dstore();
    logic [31:0] m = 32'h0001_A031;
    fire(4'd2, 8'h11, 2'd0, m, 32'h0000_1000, 32'hDEAD_0000);
    chk("R11", "entry dsi", {31'd0, entry_o}, 1);
    chk("R1", "pc dsi", pc_o, 32'h300);
    chk("R2", "dsisr miss+store", dsisr_o, 32'h4200_0000);
    chk("R2", "dar", dar_o, 32'hDEAD_0000);
    chk("R2", "srr1 dsi", srr1_o, 32'h0000_A031);
    chk("R5", "srr0 dsi", srr0_o, 32'h1000);
    chk("R7", "msr dsi", msr_o, exp_msr(m, 0));
    @(negedge clk);
    chk("R11", "entry one cycle", {31'd0, entry_o}, 0);
    fire(4'd2, 8'h02, 2'd0, m, 32'h1004, 32'h10);
    chk("R2", "dsisr prot", dsisr_o, 32'h0800_0000);
    fire(4'd2, 8'h2C, 2'd0, m, 32'h1008, 32'h20);
    chk("R2", "dsisr unsup+direct+ext", dsisr_o, 32'h8410_0000);
    fire(4'd2, 8'h03, 2'd0, m, 32'h100C, 32'h30);
    chk("R2", "dsisr miss priority", dsisr_o, 32'h4000_0000);
  endtask

  task automatic t_istore();
    logic [31:0] m = 32'h0005_8000;
    fire(4'd3, 8'h01, 2'd0, m, 32'h2000, 32'h0);
    chk("R1", "pc isi", pc_o, 32'h400);
    chk("R3", "srr1 miss", srr1_o, 32'h4000_8000);
    chk("R5", "srr0 isi", srr0_o, 32'h2000);
    chk("R11", "dar untouched by isi", dar_o, 32'h30);
    chk("R11", "dsisr untouched by isi", dsisr_o, 32'h4000_0000);
    fire(4'd3, 8'h80, 2'd0, m, 32'h2004, 32'h0);
    chk("R3", "srr1 guarded", srr1_o, 32'h1000_8000);
    fire(4'd3, 8'h02, 2'd0, m, 32'h2008, 32'h0);
    chk("R3", "srr1 other", srr1_o, 32'h0800_8000);
    fire(4'd3, 8'h41, 2'd0, m, 32'h200C, 32'h0);
    chk("R3", "srr1 miss beats noexec", srr1_o, 32'h4000_8000);
  endtask

  task automatic t_program();
    logic [31:0] m = 32'h0003_0800;
    fire(4'd6, 8'h0, 2'd0, m, 32'h3000, 32'h0);
    chk("R1", "pc prog", pc_o, 32'h700);
    chk("R4", "srr1 illegal", srr1_o, 32'h0009_0800);
    chk("R5", "srr0 prog cur", srr0_o, 32'h2FFC);
    fire(4'd6, 8'h0, 2'd1, m, 32'h3010, 32'h0);
    chk("R4", "srr1 priv", srr1_o, 32'h0005_0800);
    fire(4'd6, 8'h0, 2'd2, m, 32'h3020, 32'h0);
    chk("R4", "srr1 trap", srr1_o, 32'h0003_0800);
    fire(4'd6, 8'h0, 2'd3, m, 32'h3030, 32'h0);
    chk("R4", "srr1 fp", srr1_o, 32'h0011_0800);
    chk("R7", "msr prog fe0 cleared", msr_o, exp_msr(m, 0));
    fire(4'd6, 8'h0, 2'd3, 32'h0001_0000, 32'h3040, 32'h0);
    chk("R10", "fp dropped entry", {31'd0, entry_o}, 0);
    chk("R10", "fp dropped srr0", srr0_o, 32'h302C);
    chk("R10", "fp dropped pc", pc_o, 32'h700);
    fire(4'd5, 8'h0, 2'd0, 32'h0, 32'h4000, 32'hBEEF_0004);
    chk("R1", "pc align", pc_o, 32'h600);
    chk("R5", "srr0 align", srr0_o, 32'h3FFC);
    chk("R11", "dar align", dar_o, 32'hBEEF_0004);
    fire(4'd7, 8'h0, 2'd0, 32'h0000_2000, 32'h5000, 32'h0);
    chk("R1", "pc fpu", pc_o, 32'h800);
    chk("R5", "srr0 fpu", srr0_o, 32'h4FFC);
    chk("R5", "srr1 fpu", srr1_o, 32'h0000_2000);
    fire(4'd13, 8'h0, 2'd0, 32'h0, 32'h5100, 32'h0);
    chk("R1", "unused code no entry", {31'd0, entry_o}, 0);
  endtask

  task automatic t_mcheck();
    fire(4'd1, 8'h0, 2'd0, 32'h0000_8000, 32'h6000, 32'h0);
    chk("R8", "fatal pulse", {31'd0, fatal_o}, 1);
    chk("R8", "no entry", {31'd0, entry_o}, 0);
    chk("R8", "pc kept", pc_o, 32'h800);
    fire(4'd1, 8'h0, 2'd0, 32'h0001_9000, 32'h6100, 32'h0);
    chk("R8", "mck entry", {31'd0, entry_o}, 1);
    chk("R1", "pc mck", pc_o, 32'h200);
    chk("R8", "srr0 unchanged", srr0_o, 32'h4FFC);
    chk("R8", "msr mck", msr_o, exp_msr(32'h0001_9000, 1));
  endtask

  task automatic t_reset_exc();
    fire(4'd0, 8'h0, 2'd0, 32'h0000_0040, 32'h7000, 32'h0);
    chk("R9", "pc prefix", pc_o, 32'h0FFC_0100);
    chk("R5", "srr0 reset", srr0_o, 32'h7000);
    fire(4'd0, 8'h0, 2'd0, 32'h0, 32'h7100, 32'h0);
    chk("R9", "pc no prefix", pc_o, 32'h100);
    fire(4'd10, 8'h0, 2'd0, 32'h0, 32'h7200, 32'h0);
    chk("R1", "pc trace", pc_o, 32'hD00);
  endtask

  task automatic t_pending();
    fire(4'd4, 8'h0, 2'd0, 32'h0, 32'h8000, 32'h0);
    chk("R6", "ext deferred entry", {31'd0, entry_o}, 0);
    chk("R6", "ext pending", {30'd0, pend_o}, 2'b01);
    fire(4'd8, 8'h0, 2'd0, 32'h0, 32'h8004, 32'h0);
    chk("R6", "both pending", {30'd0, pend_o}, 2'b11);
    chk("R6", "pc untouched", pc_o, 32'hD00);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 4'd9; msr_in = 32'h0000_8000; nip_in = 32'h9000;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; nip_in = 32'h9100;
    chk("R6", "new request first", pc_o, 32'hC00);
    chk("R5", "srr0 syscall", srr0_o, 32'h9000);
    chk("R6", "still pending", {30'd0, pend_o}, 2'b11);
    @(negedge clk);
    chk("R6", "ext released", pc_o, 32'h500);
    chk("R6", "ext srr0", srr0_o, 32'h9100);
    chk("R6", "ext flag cleared", {30'd0, pend_o}, 2'b10);
    @(negedge clk);
    msr_in = 32'd0;
    chk("R6", "timer released", pc_o, 32'h900);
    chk("R6", "none pending", {30'd0, pend_o}, 2'b00);
    @(negedge clk);
    chk("R11", "quiet after", {31'd0, entry_o}, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_dstore();
    t_istore();
    t_program();
    t_mcheck();
    t_reset_exc();
    t_pending();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule